// File: doc/BRIEF.md
# Banked ROM Mapper with Built-in Nibble RAM

This block sits between an 8-bit CPU with a 16-bit address bus and a cartridge ROM. It decodes every CPU access into one of four windows: a fixed lower ROM window, a banked upper ROM window, a small RAM built into the mapper, and unmapped space. The mapper drives the external ROM address from the current bank number and the offset inside the window. It returns the byte that the ROM model supplies, a value from its own RAM, or an open-bus value of all ones.

Software controls the mapper by writing into the lower ROM window. Address bit 8 selects what the write does. When the bit is clear, the write arms or disarms the RAM. When the bit is set, the write chooses the upper ROM bank. The built-in RAM holds 512 entries that are 4 bits wide. The 512 entries repeat across the whole RAM window. On a read, the four unused upper bits come back as ones.

The RAM gate is a two-state machine. The states are `RAM_LOCKED`, which is the reset state, and `RAM_OPEN`. Two transitions connect them. **UNLOCK** goes from `RAM_LOCKED` to `RAM_OPEN` on a gate write whose data byte is exactly 0x0A. **LOCK** goes from `RAM_OPEN` to `RAM_LOCKED` on a gate write with any other data byte. A gate write that does not change the state keeps the machine where it is.

Top module: `nibble_bank_mapper`

## Requirements
- R1: A read at 0x0000–0x3FFF drives `rom_addr` = {bank field 0, cpu_addr[13:0]} and returns `rom_rdata` on `rd_data`.
- R2: A read at 0x4000–0x7FFF drives `rom_addr` = {bank, cpu_addr[13:0]}. The bank field occupies `rom_addr[17:14]`, and the read returns `rom_rdata`.
- R3: A write at 0x0000–0x3FFF with cpu_addr[8]=0 opens the RAM only when the data byte equals 0x0A exactly. Any other byte, for example 0x1A or 0x0B, locks it.
- R4: A write at 0x0000–0x3FFF with cpu_addr[8]=1 loads the bank from data[3:0] and ignores data[7:4]. A value of 0 is stored as 1, so the bank is never 0.
- R5: The RAM has 512 entries, indexed by cpu_addr[8:0]. Every 512-byte slice of 0xA000–0xBFFF reaches the same entries.
- R6: A RAM read while the RAM is open returns {4'hF, stored nibble}.
- R7: A RAM write while the RAM is open stores data[3:0] only. A RAM write while it is locked leaves the entry unchanged.
- R8: `rd_data` is 0xFF in each of these cases: a read at 0x8000–0x9FFF, a read at 0xC000–0xFFFF, a RAM read while the RAM is locked, and any cycle with `cpu_rd` low.
- R9: Reset leaves the RAM locked and the bank at 1.
- R10: Writes to 0x4000–0x7FFF, 0x8000–0x9FFF and 0xC000–0xFFFF change neither the bank nor the RAM gate. Register and RAM updates occur on the rising clock edge at which `cpu_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, sampled at the rising edge |
| rom_rdata | input | 8 | Byte returned by the external ROM at `rom_addr` |
| rd_data | output | 8 | Read data to the CPU (combinational) |
| rom_addr | output | 18 | External ROM address {bank, offset} |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high in the same cycle. They also assume that address and data are stable around each rising edge. The bench drives every access on the falling edge and raises only one strobe at a time. The write-then-read property also assumes that a RAM read in the cycle after a write sees the written value, because the read path is combinational. The bench reads back only after the write edge has passed.

// File: rtl/nbm_pkg.sv
package nbm_pkg;

    typedef enum logic [1:0] {
        WIN_ROM_FIXED,
        WIN_ROM_BANKED,
        WIN_NIBBLE_RAM,
        WIN_UNMAPPED
    } win_e;

    typedef enum logic {
        RAM_LOCKED = 1'b0,
        RAM_OPEN   = 1'b1
    } ram_state_e;

    localparam logic [7:0] UNLOCK_KEY = 8'h0A;
    localparam logic [7:0] OPEN_BUS   = 8'hFF;

endpackage

// File: rtl/nbm_decode.sv
module nbm_decode
    import nbm_pkg::*;
(
    input  logic [2:0] addr_top,   // cpu_addr[15:13]
    output win_e       win
);

    always_comb begin
        unique case (addr_top)
            3'b000, 3'b001: win = WIN_ROM_FIXED;
            3'b010, 3'b011: win = WIN_ROM_BANKED;
            3'b101:         win = WIN_NIBBLE_RAM;
            default:        win = WIN_UNMAPPED;
        endcase
    end

endmodule

// File: rtl/nbm_ctrl.sv
module nbm_ctrl
    import nbm_pkg::*;
#(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,     // write into the fixed window
    input  logic              sel_bank,   // address bit 8
    input  logic [7:0]        wdata,
    output ram_state_e        ram_state,
    output logic [BANK_W-1:0] bank
);

    localparam logic [BANK_W-1:0] BANK_ONE  = BANK_W'(1);
    localparam logic [BANK_W-1:0] BANK_ZERO = '0;

    ram_state_e        state_q, state_d;
    logic [BANK_W-1:0] bank_q, bank_d;
    logic              gate_wr, bank_wr;

    assign gate_wr = reg_wr && !sel_bank;
    assign bank_wr = reg_wr &&  sel_bank;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RAM_LOCKED;
            bank_q  <= BANK_ONE;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
        end
    end

    // next state and bank
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RAM_LOCKED: if (gate_wr && wdata == UNLOCK_KEY) state_d = RAM_OPEN;
            RAM_OPEN:   if (gate_wr && wdata != UNLOCK_KEY) state_d = RAM_LOCKED;
            default:    state_d = RAM_LOCKED;
        endcase
        bank_d = bank_q;
        if (bank_wr) begin
            bank_d = (wdata[BANK_W-1:0] == BANK_ZERO) ? BANK_ONE : wdata[BANK_W-1:0];
        end
    end

    // outputs
    always_comb begin
        ram_state = state_q;
        bank      = bank_q;
    end

    assert_bank_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q != BANK_ZERO);
    assert_bank_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr && wdata[BANK_W-1:0] != BANK_ZERO) |=> bank_q == $past(wdata[BANK_W-1:0]));
    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr |=> $stable(bank_q));
    assert_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_wr && wdata == UNLOCK_KEY) |=> state_q == RAM_OPEN);
    assert_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_wr && wdata != UNLOCK_KEY) |=> state_q == RAM_LOCKED);
    assert_gate_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_wr |=> $stable(state_q));

endmodule

// File: rtl/nbm_nibble_ram.sv
module nbm_nibble_ram #(
    parameter int AW = 9,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/nibble_bank_mapper.sv
module nibble_bank_mapper
    import nbm_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int RAM_AW = 9,
    parameter int NIB_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [15:0]               cpu_addr,
    input  logic [7:0]                cpu_wdata,
    input  logic                      cpu_rd,
    input  logic                      cpu_wr,
    input  logic [7:0]                rom_rdata,
    output logic [7:0]                rd_data,
    output logic [BANK_W+14-1:0]      rom_addr
);

    localparam int OFS_W  = 14;
    localparam int ROM_AW = BANK_W + OFS_W;
    localparam int PAD_W  = 8 - NIB_W;

    win_e              win;
    ram_state_e        ram_state;
    logic [BANK_W-1:0] bank;
    logic [NIB_W-1:0]  ram_rd;
    logic              ram_we;
    logic [7:0]        rd_mux;

    nbm_decode u_decode (
        .addr_top (cpu_addr[15:13]),
        .win      (win)
    );

    nbm_ctrl #(.BANK_W(BANK_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (cpu_wr && win == WIN_ROM_FIXED),
        .sel_bank  (cpu_addr[8]),
        .wdata     (cpu_wdata),
        .ram_state (ram_state),
        .bank      (bank)
    );

    assign ram_we = cpu_wr && win == WIN_NIBBLE_RAM && ram_state == RAM_OPEN;

    nbm_nibble_ram #(.AW(RAM_AW), .DW(NIB_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (cpu_addr[RAM_AW-1:0]),
        .wdata (cpu_wdata[NIB_W-1:0]),
        .rdata (ram_rd)
    );

    always_comb begin
        unique case (win)
            WIN_ROM_FIXED, WIN_ROM_BANKED: rd_mux = rom_rdata;
            WIN_NIBBLE_RAM: rd_mux = (ram_state == RAM_OPEN) ? {{PAD_W{1'b1}}, ram_rd} : OPEN_BUS;
            default:        rd_mux = OPEN_BUS;
        endcase
        rd_data  = cpu_rd ? rd_mux : OPEN_BUS;
        rom_addr = {(win == WIN_ROM_BANKED) ? bank : {BANK_W{1'b0}}, cpu_addr[OFS_W-1:0]};
    end

    assert_fixed_bank0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> rom_addr[ROM_AW-1:OFS_W] == '0);
    assert_banked_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b01) |-> rom_addr[ROM_AW-1:OFS_W] != '0);
    assert_ram_upper_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[15:13] == 3'b101) |-> rd_data[7:4] == 4'hF);
    assert_locked_open_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[15:13] == 3'b101 && ram_state == RAM_LOCKED) |-> rd_data == 8'hFF);
    assert_unmapped_open_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[15] && !(cpu_addr[14:13] == 2'b01)) |-> rd_data == 8'hFF);
    assert_store_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> ((cpu_rd && cpu_addr == $past(cpu_addr)) -> rd_data[3:0] == $past(cpu_wdata[3:0])));

endmodule

// File: tb/test_nibble_bank_mapper.sv
module test_nibble_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  rom_rdata;
    logic [7:0]  rd_data;
    logic [17:0] rom_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [3:0] m_ram [512];

    always #10 clk = ~clk;

    function automatic logic [7:0] rom_fn(input logic [17:0] a);
        return a[7:0] ^ {a[17:14], a[11:8]};
    endfunction

    assign rom_rdata = rom_fn(rom_addr);

    nibble_bank_mapper i_nibble_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_rdata(rom_rdata),
        .rd_data(rd_data), .rom_addr(rom_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // read at address a; expected bank / RAM gate supplied by the caller's scenario
    task automatic rd(input string tag, input logic [15:0] a, input logic [3:0] bank, input bit open);
        logic [17:0] ea;
        logic [7:0]  ed;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #5;
        if (a[15:14] == 2'b00) begin
            ea = {4'd0, a[13:0]}; ed = rom_fn(ea);
            chk({tag, " R1 addr"}, 32'(rom_addr), 32'(ea));
        end else if (a[15:14] == 2'b01) begin
            ea = {bank, a[13:0]}; ed = rom_fn(ea);
            chk({tag, " R2 addr"}, 32'(rom_addr), 32'(ea));
        end else if (a[15:13] == 3'b101) begin
            ed = open ? {4'hF, m_ram[a[8:0]]} : 8'hFF;
        end else begin
            ed = 8'hFF;
        end
        chk(tag, 32'(rd_data), 32'(ed));
        cpu_rd = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rd("R9 reset bank", 16'h4000, 4'd1, 0);
        rd("R9 reset locked", 16'hA000, 4'd1, 0);

        // R4 bank sweep, upper data bits ignored; R1 fixed window stays bank 0
        for (int b = 0; b < 16; b++) begin
            logic [3:0] eb;
            eb = (b == 0) ? 4'd1 : 4'(b);
            wr(16'h2100, {4'hA, 4'(b)});
            rd("R4 bank sweep", 16'h4000 + 16'(b * 16'h0123), eb, 0);
            rd("R2 bank top", 16'h7FFF, eb, 0);
            rd("R1 fixed window", 16'h0000 + 16'(b * 16'h0311), eb, 0);
        end
        wr(16'h0100, 8'h07);
        rd("R4 low alias", 16'h5555, 4'd7, 0);
        wr(16'h3F00, 8'h00);
        rd("R4 zero to one", 16'h6000, 4'd1, 0);
        wr(16'h2100, 8'h05);

        // R3 unlock, R5/R7 RAM sweep
        wr(16'h0000, 8'h0A);
        for (int i = 0; i < 512; i++) begin
            logic [7:0] d;
            d = 8'(i) ^ 8'h5A ^ 8'(i >> 4);
            wr(16'hA000 + 16'(i), d);
            m_ram[i] = d[3:0];
        end
        for (int i = 0; i < 512; i++) begin
            rd("R6 readback", 16'hA000 + 16'(i), 4'd5, 1);
        end
        for (int k = 0; k < 16; k++) begin
            rd("R5 mirror", 16'hA000 + 16'(k * 512) + 16'((k * 37) % 512), 4'd5, 1);
        end

        // R3 lock with non-key values; R7 locked write ignored
        wr(16'h1000, 8'h0B);
        rd("R3 lock 0B", 16'hA005, 4'd5, 0);
        wr(16'hA005, 8'h03);
        wr(16'h1000, 8'h0A);
        rd("R7 locked write ignored", 16'hA005, 4'd5, 1);
        wr(16'hB005, 8'hF9);
        m_ram[5] = 4'h9;
        rd("R7 nibble only", 16'hA005, 4'd5, 1);
        wr(16'h0000, 8'h1A);
        rd("R3 1A locks", 16'hA005, 4'd5, 0);

        // R10 ignored regions
        wr(16'h4000, 8'h0A);
        wr(16'h9000, 8'h0A);
        wr(16'hC000, 8'h0A);
        rd("R10 gate unchanged", 16'hA005, 4'd5, 0);
        wr(16'h4100, 8'h03);
        wr(16'h8100, 8'h03);
        wr(16'hE100, 8'h03);
        rd("R10 bank unchanged", 16'h4ABC, 4'd5, 0);

        // R8 open bus
        wr(16'h0000, 8'h0A);
        rd("R8 8000", 16'h8000, 4'd5, 1);
        rd("R8 9FFF", 16'h9FFF, 4'd5, 1);
        rd("R8 C000", 16'hC000, 4'd5, 1);
        rd("R8 FFFF", 16'hFFFF, 4'd5, 1);
        @(negedge clk);
        cpu_addr = 16'hA005; cpu_rd = 1'b0;
        #5 chk("R8 rd low", 32'(rd_data), 32'hFF);

        // R9 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd("R9 re-reset bank", 16'h4321, 4'd1, 0);
        rd("R9 re-reset locked", 16'hA005, 4'd1, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule